// File: doc/BRIEF.md
# Mask-Gated PSW Exchange Interrupt Unit

This block holds the processor's current program status word (PSW) and performs interrupt entry by exchanging PSWs through fixed slots in low memory. The 64-bit PSW carries the instruction address in its low word and a per-class interrupt enable mask in its high word. Five external request classes and one synchronous fault request feed pending latches. The instruction sequencer pulses a boundary strobe between instructions, and only then is an enabled request serviced.

Servicing a request saves the current PSW into the class's old slot, then fetches the class's new PSW from the neighbouring slot, which redirects execution. There is no level register and no vector table. The effective ranking among classes comes entirely from the mask bits that software places in each new PSW. A fixed order only breaks ties among requests that are enabled at the same moment.

After every exchange the pending set is examined again, so chained exchanges run back to back before any instruction issues. The sequencer restores a PSW on interrupt return through a load-PSW input that is applied at a boundary. A stall output holds off instruction issue while an exchange or a re-check is in progress.

Top module: `psw_swap_unit`

## Requirements
- R1: After synchronous reset, cur_psw equals {32'h0, RESET_IA} (mask all clear), stall is low, and neither mem_wr nor mem_rd is asserted.
- R2: PSW layout: bits [31:0] hold the instruction address and bit 32+i enables class i. Class c (0..4) owns an old slot at SLOT_BASE+16c and a new slot at SLOT_BASE+16c+8. The fault uses class index 5. Each slot stores its low word at the slot address and its high word at slot address+4.
- R3: A cycle with irq_req[i] high sets pending for class i, and that pending state persists across cycles, with no boundary present, until the class is serviced.
- R4: No exchange starts except at a cycle where insn_bnd is high while the unit is idle; pending requests alone leave stall low and the memory port quiet.
- R5: A pending request whose mask bit is clear is not serviced and stays pending. It is serviced as soon as a later PSW, loaded at a boundary, sets its mask bit.
- R6: An exchange for class c occupies consecutive cycles with the following accesses: write of old low word, write of old high word, read of new low word, read of new high word, a load cycle, and a re-check cycle. mem_rdata is taken one cycle after each read address. cur_psw holds the fetched PSW from the re-check cycle on.
- R7: Among several enabled pending external classes, the lowest class number is serviced first.
- R8: If the re-check finds another enabled or fault request, the next exchange's first write follows in the very next cycle, with no idle cycle between the two exchanges.
- R9: A pending fault is serviced at a boundary ahead of every external request, regardless of the mask, using the class-5 slots.
- R10: stall is high for exactly 6 cycles per exchange, plus 1 re-check cycle after each boundary PSW load, and is low otherwise.
- R11: ld_psw_valid together with insn_bnd in the idle state replaces cur_psw at the next edge and is followed by one re-check cycle. ld_psw_valid without insn_bnd leaves cur_psw unchanged.
- R12: A class's pending state is cleared by the write of its old PSW's high word, so a serviced class is not taken again unless it is requested anew.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NCLS | External request per class, sets the pending latch |
| fault_req | input | 1 | Synchronous fault request, sets the fault pending latch |
| insn_bnd | input | 1 | Instruction boundary strobe from the sequencer |
| ld_psw_valid | input | 1 | Load-PSW request for interrupt return |
| ld_psw_data | input | 2*WORD_W | PSW value to load |
| mem_addr | output | MEM_AW | Byte address of the slot word accessed |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | WORD_W | Write data |
| mem_rd | output | 1 | Read strobe, data returned one cycle later |
| mem_rdata | input | WORD_W | Read data |
| cur_psw | output | 2*WORD_W | Current PSW |
| stall | output | 1 | Holds off instruction issue |

## Verification
On every cycle, the assertions check several local properties. Pending bits are never lost before service. Writes and reads never overlap. Each old-slot low write is followed by the high write at +4. The first access after a boundary with a fault pending targets the fault slot. An exchange never saves a PSW that masks the class it services. A re-check with work left leads straight into a write. cur_psw moves only in a load cycle or at a boundary load. The ordering across a whole chain of exchanges needs the bench's sweep over every mask and request pattern to show it. So do the saved words and the final PSW after mask-driven reordering, and the exact stall length.

// File: rtl/psw_swap_pkg.sv
package psw_swap_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_LO,
    ST_WR_HI,
    ST_RD_LO,
    ST_RD_HI,
    ST_LOAD,
    ST_CHECK
  } swap_state_e;

endpackage

// File: rtl/psw_pend_bank.sv
module psw_pend_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           pend_o[i] <= 1'b0;
      else if (set_i[i]) pend_o[i] <= 1'b1;
      else if (clr_i[i]) pend_o[i] <= 1'b0;
    end

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
      (pend_o[i] && !clr_i[i]) |=> pend_o[i]);   // R3
    AST_PEND_CAPTURE: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> pend_o[i]);                     // R3
  end

endmodule

// File: rtl/psw_prio_pick.sv
module psw_prio_pick #(
  parameter int N = 5,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);

  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/psw_slot_addr.sv
module psw_slot_addr #(
  parameter int MEM_AW      = 16,
  parameter int SLOT_BASE   = 0,
  parameter int SLOT_STRIDE = 16,
  parameter int WORD_BYTES  = 4,
  parameter int CLS_W       = 3
) (
  input  logic [CLS_W-1:0]  cls_i,
  input  logic              new_i,
  input  logic              hi_i,
  output logic [MEM_AW-1:0] addr_o
);

  localparam logic [MEM_AW-1:0] BASE_A   = MEM_AW'(SLOT_BASE);
  localparam logic [MEM_AW-1:0] STRIDE_A = MEM_AW'(SLOT_STRIDE);
  localparam logic [MEM_AW-1:0] NEW_OFS  = MEM_AW'(SLOT_STRIDE / 2);
  localparam logic [MEM_AW-1:0] HI_OFS   = MEM_AW'(WORD_BYTES);

  always_comb begin
    addr_o = BASE_A + MEM_AW'(cls_i) * STRIDE_A;
    if (new_i) addr_o = addr_o + NEW_OFS;
    if (hi_i)  addr_o = addr_o + HI_OFS;
  end

endmodule

// File: rtl/psw_swap_unit.sv
module psw_swap_unit
  import psw_swap_pkg::*;
#(
  parameter int NCLS        = 5,
  parameter int WORD_W      = 32,
  parameter int MEM_AW      = 16,
  parameter int SLOT_BASE   = 0,
  parameter int SLOT_STRIDE = 16,
  parameter logic [WORD_W-1:0] RESET_IA = 'h100
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCLS-1:0]       irq_req,
  input  logic                  fault_req,
  input  logic                  insn_bnd,
  input  logic                  ld_psw_valid,
  input  logic [2*WORD_W-1:0]   ld_psw_data,
  output logic [MEM_AW-1:0]     mem_addr,
  output logic                  mem_wr,
  output logic [WORD_W-1:0]     mem_wdata,
  output logic                  mem_rd,
  input  logic [WORD_W-1:0]     mem_rdata,
  output logic [2*WORD_W-1:0]   cur_psw,
  output logic                  stall
);

  localparam int PSW_W      = 2 * WORD_W;
  localparam int NSLOT      = NCLS + 1;
  localparam int CLS_W      = $clog2(NSLOT);
  localparam int PICK_W     = (NCLS > 1) ? $clog2(NCLS) : 1;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam logic [CLS_W-1:0]  FAULT_CLS = CLS_W'(NCLS);
  localparam logic [MEM_AW-1:0] FAULT_OLD = MEM_AW'(SLOT_BASE + NCLS * SLOT_STRIDE);

  swap_state_e        state_q;
  logic [CLS_W-1:0]   sel_q;
  logic [PSW_W-1:0]   psw_q;
  logic [WORD_W-1:0]  lo_q;
  logic               fault_pend_q;

  logic [NCLS-1:0]    pend;
  logic [NCLS-1:0]    clr_ext;
  logic [NCLS-1:0]    enabled;
  logic [NCLS-1:0]    mask;
  logic               pick_any;
  logic [PICK_W-1:0]  pick_idx;
  logic               want_swap;
  logic [CLS_W-1:0]   next_cls;
  logic               bnd_idle;
  logic               slot_new;
  logic               slot_hi;

  // pending state
  always_comb begin
    clr_ext = '0;
    if (state_q == ST_WR_HI && sel_q != FAULT_CLS) clr_ext[sel_q] = 1'b1;
  end

  psw_pend_bank #(.N(NCLS)) u_pend (
    .clk    (clk),
    .rst    (rst),
    .set_i  (irq_req),
    .clr_i  (clr_ext),
    .pend_o (pend)
  );

  always_ff @(posedge clk) begin
    if (rst)                                           fault_pend_q <= 1'b0;
    else if (fault_req)                                fault_pend_q <= 1'b1;
    else if (state_q == ST_WR_HI && sel_q == FAULT_CLS) fault_pend_q <= 1'b0;
  end

  // mask gating and tie-break
  assign mask    = psw_q[WORD_W +: NCLS];
  assign enabled = pend & mask;

  psw_prio_pick #(.N(NCLS)) u_pick (
    .req_i (enabled),
    .any_o (pick_any),
    .idx_o (pick_idx)
  );

  assign want_swap = fault_pend_q || pick_any;
  assign next_cls  = fault_pend_q ? FAULT_CLS : CLS_W'(pick_idx);
  assign bnd_idle  = (state_q == ST_IDLE) && insn_bnd;

  // exchange sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
      psw_q   <= {{WORD_W{1'b0}}, RESET_IA};
      lo_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (insn_bnd && ld_psw_valid) begin
            psw_q   <= ld_psw_data;
            state_q <= ST_CHECK;
          end else if (insn_bnd && want_swap) begin
            sel_q   <= next_cls;
            state_q <= ST_WR_LO;
          end
        end
        ST_WR_LO: state_q <= ST_WR_HI;
        ST_WR_HI: state_q <= ST_RD_LO;
        ST_RD_LO: state_q <= ST_RD_HI;
        ST_RD_HI: begin
          lo_q    <= mem_rdata;
          state_q <= ST_LOAD;
        end
        ST_LOAD: begin
          psw_q   <= {mem_rdata, lo_q};
          state_q <= ST_CHECK;
        end
        ST_CHECK: begin
          if (want_swap) begin
            sel_q   <= next_cls;
            state_q <= ST_WR_LO;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // memory port decode from registered state
  assign slot_new = (state_q == ST_RD_LO) || (state_q == ST_RD_HI);
  assign slot_hi  = (state_q == ST_WR_HI) || (state_q == ST_RD_HI);

  psw_slot_addr #(
    .MEM_AW      (MEM_AW),
    .SLOT_BASE   (SLOT_BASE),
    .SLOT_STRIDE (SLOT_STRIDE),
    .WORD_BYTES  (WORD_BYTES),
    .CLS_W       (CLS_W)
  ) u_addr (
    .cls_i  (sel_q),
    .new_i  (slot_new),
    .hi_i   (slot_hi),
    .addr_o (mem_addr)
  );

  assign mem_wr    = (state_q == ST_WR_LO) || (state_q == ST_WR_HI);
  assign mem_rd    = slot_new;
  assign mem_wdata = !mem_wr ? '0 :
                     (state_q == ST_WR_HI) ? psw_q[PSW_W-1:WORD_W] : psw_q[WORD_W-1:0];
  assign cur_psw   = psw_q;
  assign stall     = (state_q != ST_IDLE);

  // checks
  AST_PORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(mem_wr && mem_rd));                                                   // R6
  AST_HI_AFTER_LO: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WR_LO) |=> (mem_wr && mem_addr == $past(mem_addr) + MEM_AW'(WORD_BYTES))); // R6
  AST_SAVED_ENABLED: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WR_LO && sel_q != FAULT_CLS) |-> cur_psw[WORD_W + int'(sel_q)]); // R5
  AST_BOUNDARY_ONLY: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !insn_bnd) |=> !stall);                         // R4
  AST_FAULT_FIRST: assert property (@(posedge clk) disable iff (rst)
    (bnd_idle && !ld_psw_valid && fault_pend_q) |=> (mem_wr && mem_addr == FAULT_OLD)); // R9
  AST_NO_GAP: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CHECK && want_swap) |=> mem_wr);                         // R8
  AST_PSW_HELD: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_LOAD && !(bnd_idle && ld_psw_valid)) |=> $stable(cur_psw)); // R11

endmodule

// File: tb/psw_swap_unit_tb_top.sv
`timescale 1ns/1ps
module psw_swap_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  irq_req;
  logic        fault_req;
  logic        insn_bnd;
  logic        ld_psw_valid;
  logic [63:0] ld_psw_data;
  logic [15:0] mem_addr;
  logic        mem_wr;
  logic [31:0] mem_wdata;
  logic        mem_rd;
  logic [31:0] mem_rdata;
  logic [63:0] cur_psw;
  logic        stall;

  int checks = 0;
  int errors = 0;

  // monitor state
  logic        mon_en = 1'b0;
  int          stall_cnt;
  int          log_n;
  logic [15:0] log_addr [0:15];
  logic [31:0] log_data [0:15];

  always #5 clk = ~clk;

  psw_swap_unit dut_i (
    .clk          (clk),
    .rst          (rst),
    .irq_req      (irq_req),
    .fault_req    (fault_req),
    .insn_bnd     (insn_bnd),
    .ld_psw_valid (ld_psw_valid),
    .ld_psw_data  (ld_psw_data),
    .mem_addr     (mem_addr),
    .mem_wr       (mem_wr),
    .mem_wdata    (mem_wdata),
    .mem_rd       (mem_rd),
    .mem_rdata    (mem_rdata),
    .cur_psw      (cur_psw),
    .stall        (stall)
  );

  // new-PSW slot contents: class c -> addr 0x1000+256c, mask = bits below c; fault -> 0x2000, mask 0
  function automatic logic [31:0] new_word(input logic [15:0] a);
    int c = int'(a[6:4]);
    if (c == 5) return a[2] ? 32'h0 : 32'h2000;
    return a[2] ? 32'((1 << c) - 1) : 32'h1000 + 32'(c * 256);
  endfunction

  function automatic logic [63:0] new_psw(input int c);
    if (c == 5) return 64'h2000;
    return {32'((1 << c) - 1), 32'h1000 + 32'(c * 256)};
  endfunction

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= new_word(mem_addr);
  end

  always @(negedge clk) begin
    if (mon_en) begin
      if (stall) stall_cnt++;
      if (mem_wr && log_n < 16) begin
        log_addr[log_n] = mem_addr;
        log_data[log_n] = mem_wdata;
        log_n++;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    stall_cnt = 0;
    log_n     = 0;
    mon_en    = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; irq_req = '0; fault_req = 1'b0; insn_bnd = 1'b0;
    ld_psw_valid = 1'b0; ld_psw_data = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic load_at_bnd(input logic [63:0] v);
    @(negedge clk);
    insn_bnd = 1'b1; ld_psw_valid = 1'b1; ld_psw_data = v;
    @(negedge clk);
    insn_bnd = 1'b0; ld_psw_valid = 1'b0;
  endtask

  task automatic pulse_irq(input logic [4:0] p, input logic f);
    @(negedge clk);
    irq_req = p; fault_req = f;
    @(negedge clk);
    irq_req = '0; fault_req = 1'b0;
  endtask

  task automatic pulse_bnd();
    @(negedge clk);
    insn_bnd = 1'b1;
    @(negedge clk);
    insn_bnd = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst = 1'b1; irq_req = '0; fault_req = 1'b0; insn_bnd = 1'b0;
    ld_psw_valid = 1'b0; ld_psw_data = '0;
    log_n = 0; stall_cnt = 0;
    do_reset();

    // R1 reset state
    chk("R1 cur_psw", cur_psw, {32'h0, 32'h100});
    chk("R1 stall", {63'h0, stall}, 64'h0);
    chk("R1 port idle", {62'h0, mem_wr, mem_rd}, 64'h0);

    // R4 / R3: request without boundary
    load_at_bnd({32'h1f, 32'h500});
    wait_cyc(3);
    clear_mon();
    pulse_irq(5'b00100, 1'b0);
    wait_cyc(8);
    chk("R4 no stall without boundary", 64'(stall_cnt), 64'd0);
    chk("R4 no access without boundary", 64'(log_n), 64'd0);

    // R6 / R2 cycle-by-cycle exchange of class 2, pending kept (R3)
    @(negedge clk);
    insn_bnd = 1'b1;
    @(negedge clk);
    insn_bnd = 1'b0;
    chk("R3 R6 R2 old low write", {mem_wr, mem_rd, mem_addr, mem_wdata}, {2'b10, 16'h20, 32'h500});
    @(negedge clk);
    chk("R6 R2 old high write", {mem_wr, mem_rd, mem_addr, mem_wdata}, {2'b10, 16'h24, 32'h1f});
    @(negedge clk);
    chk("R6 R2 new low read", {mem_wr, mem_rd, mem_addr}, {2'b01, 16'h28});
    @(negedge clk);
    chk("R6 R2 new high read", {mem_wr, mem_rd, mem_addr}, {2'b01, 16'h2c});
    @(negedge clk);
    chk("R6 load cycle", {stall, mem_wr, mem_rd}, 3'b100);
    @(negedge clk);
    chk("R6 new psw", cur_psw, {32'h3, 32'h1200});
    chk("R10 stall in recheck", {63'h0, stall}, 64'h1);
    @(negedge clk);
    chk("R10 stall ends", {63'h0, stall}, 64'h0);
    chk("R10 stall count", 64'(stall_cnt), 64'd6);

    // R11 load without boundary ignored
    @(negedge clk);
    ld_psw_valid = 1'b1; ld_psw_data = 64'h0000_001f_0000_0abc;
    wait_cyc(3);
    ld_psw_valid = 1'b0;
    chk("R11 load ignored", cur_psw, {32'h3, 32'h1200});
    clear_mon();
    load_at_bnd(64'h0000_0000_0000_0abc);
    chk("R11 load applied", cur_psw, 64'h0000_0000_0000_0abc);
    chk("R11 recheck stall", {63'h0, stall}, 64'h1);
    @(negedge clk);
    chk("R11 recheck one cycle", {63'h0, stall}, 64'h0);

    // R9 fault ahead of masked irq, then R5 unmask, then R12
    do_reset();
    load_at_bnd({32'h0, 32'h700});
    wait_cyc(2);
    pulse_irq(5'b00001, 1'b1);
    clear_mon();
    pulse_bnd();
    wait_cyc(10);
    chk("R9 fault log count", 64'(log_n), 64'd2);
    chk("R9 fault old low", {log_addr[0], log_data[0]}, {16'h50, 32'h700});
    chk("R9 fault old high", {log_addr[1], log_data[1]}, {16'h54, 32'h0});
    chk("R9 fault new psw", cur_psw, new_psw(5));
    clear_mon();
    load_at_bnd({32'h1f, 32'h800});
    wait_cyc(10);
    chk("R5 masked class later taken", {log_addr[0], log_data[0]}, {16'h00, 32'h800});
    chk("R5 psw after unmask", cur_psw, new_psw(0));
    chk("R10 stall load plus swap", 64'(stall_cnt), 64'd7);
    clear_mon();
    load_at_bnd({32'h1f, 32'h900});
    wait_cyc(4);
    chk("R12 serviced class not retaken", 64'(log_n), 64'd0);
    chk("R12 recheck only", 64'(stall_cnt), 64'd1);

    // Sweep: every mask and every nonzero request pattern (R7, R8, R5, R6, R10)
    for (int m = 0; m < 32; m++) begin
      for (int p = 1; p < 32; p++) begin
        logic [63:0] psw;
        logic [4:0]  pp;
        logic [15:0] ea [0:15];
        logic [31:0] ed [0:15];
        int          n;
        int          bad;
        do_reset();
        load_at_bnd({32'(m), 32'h4000 + 32'(m)});
        wait_cyc(2);
        clear_mon();
        pulse_irq(5'(p), 1'b0);
        pulse_bnd();
        wait_cyc(45);
        psw = {32'(m), 32'h4000 + 32'(m)};
        pp  = 5'(p);
        n   = 0;
        while ((pp & psw[36:32]) != 0) begin
          int c = 0;
          for (int k = 4; k >= 0; k--) if (pp[k] && psw[32+k]) c = k;
          ea[2*n]   = 16'(16 * c);
          ed[2*n]   = psw[31:0];
          ea[2*n+1] = 16'(16 * c + 4);
          ed[2*n+1] = psw[63:32];
          pp[c] = 1'b0;
          psw   = new_psw(c);
          n++;
        end
        chk("R7 R8 final psw", cur_psw, psw);
        chk("R10 R8 stall cycles", 64'(stall_cnt), 64'(6 * n));
        bad = (log_n != 2 * n) ? 1 : 0;
        for (int k = 0; k < 2 * n && k < log_n; k++)
          if (log_addr[k] !== ea[k] || log_data[k] !== ed[k]) bad = 1;
        chk("R7 R6 save order", 64'(bad), 64'd0);
      end
    end

    mon_en = 1'b0;
    summary();
  end

endmodule